// File: doc/BRIEF.md
# Tick-Sequenced Microcontrol Unit

This block produces every timing and control strobe for a small 4-bit machine that has one shared bus and four instructions. A ring of ten one-hot ticks sets the pace of each machine cycle. The first two ticks fetch the next instruction and step the program counter. The next two ticks carry out the instruction held on the instruction input. The remaining six ticks are idle.

The current instruction word is decoded into four one-hot instruction lines. A fixed sum-of-products matrix combines those lines with the tick vector to produce the load and bus-drive enables for the program counter, the address register, registers A and B, and the sum register. The tick vector is the only state in the block. The enables are combinational functions of the tick vector and the instruction input, so a datapath sees them in the same cycle as the tick that causes them.

Top module: `tick_ctl_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the tick vector becomes T0 (`tick` == 1, bit 0 set) after that edge. The reset is synchronous and active high.
- R2: Exactly one bit of `tick` is high at any time. Bit k stands for tick Tk. Each clock edge with `en` high moves the tick from Tk to Tk+1, and from T9 back to T0.
- R3: A clock edge with `en` low leaves `tick` unchanged.
- R4: In T0, `pc_drive`, `mar_load` and `sum_load` are high. In T1, `pc_load` and `sum_drive` are high. These hold for every instruction value, and no other enable is high in T0 or T1.
- R5: The instruction field is the whole 4-bit `instr` input. Values 4 to 15 are no-ops: in T2 and T3 every enable is low.
- R6: A move uses only T2. Code 0 (copy A into B) raises `a_drive` and `b_load`. Code 1 (copy B into A) raises `b_drive` and `a_load`. In T3 a move raises no enable.
- R7: An increment uses T2 and T3. Code 2 (increment A) raises `a_drive` and `sum_load` in T2, then `sum_drive` and `a_load` in T3. Code 3 (increment B) does the same with `b_drive` and `b_load` in place of the A enables.
- R8: In ticks T4 to T9 every enable is low, whatever the instruction.
- R9: At most one of the bus-drive enables (`pc_drive`, `a_drive`, `b_drive`, `sum_drive`) is high in any tick, for any instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to T0 |
| en | input | 1 | Advance the tick ring at this edge |
| instr | input | 4 | Instruction word |
| tick | output | 10 | One-hot tick vector, bit k = Tk |
| pc_load | output | 1 | Program counter loads from the bus |
| pc_drive | output | 1 | Program counter drives the bus |
| mar_load | output | 1 | Address register loads from the bus |
| a_load | output | 1 | Register A loads from the bus |
| a_drive | output | 1 | Register A drives the bus |
| b_load | output | 1 | Register B loads from the bus |
| b_drive | output | 1 | Register B drives the bus |
| sum_load | output | 1 | Sum register captures the incremented bus value |
| sum_drive | output | 1 | Sum register drives the bus |

## Verification
Several properties are checked on every cycle: the tick stays one-hot, it rotates on enabled edges and holds on disabled ones, reset returns it to T0, the fetch ticks carry their fixed enables, idle ticks and no-op codes are silent, and no two bus drivers are active together. The exact enable set for each instruction in T2 and T3 cannot be shown by those properties. The bench's cycle-by-cycle reference model shows it across all sixteen codes, with stalled cycles, a reset in the middle of a cycle, instruction changes within a cycle, and a short program run.

// File: rtl/tick_ctl_pkg.sv
`timescale 1ns/1ps
package tick_ctl_pkg;

  // number of instruction lines and the code each one answers to
  localparam int N_OPS      = 4;
  localparam int OP_MOV_A2B = 0;
  localparam int OP_MOV_B2A = 1;
  localparam int OP_INC_A   = 2;
  localparam int OP_INC_B   = 3;

  // ticks that can raise an enable
  localparam int WORK_TICKS = 4;

  typedef struct packed {
    logic pc_load;
    logic pc_drive;
    logic mar_load;
    logic a_load;
    logic a_drive;
    logic b_load;
    logic b_drive;
    logic sum_load;
    logic sum_drive;
  } ctl_t;

  // number of bus drivers active in a control word
  function automatic int drivers_on(input ctl_t c);
    return int'(c.pc_drive) + int'(c.a_drive) + int'(c.b_drive) + int'(c.sum_drive);
  endfunction

endpackage

// File: rtl/tick_ring.sv
`timescale 1ns/1ps
module tick_ring #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [N-1:0] ring,
  output logic         wrap
);
  localparam logic [N-1:0] HOME = {{(N-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)       ring <= HOME;
    else if (step) ring <= {ring[N-2:0], ring[N-1]};
  end

  assign wrap = step & ring[N-1];
endmodule

// File: rtl/op_decode.sv
`timescale 1ns/1ps
module op_decode #(
  parameter int W     = 4,
  parameter int LINES = 4
) (
  input  logic [W-1:0]     code,
  output logic [LINES-1:0] line,
  output logic             noop
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [W-1:0] KEY = W'(i);
    assign line[i] = (code == KEY);
  end

  assign noop = ~|line;
endmodule

// File: rtl/ctl_matrix.sv
`timescale 1ns/1ps
module ctl_matrix
  import tick_ctl_pkg::*;
(
  input  logic [WORK_TICKS-1:0] t,
  input  logic [N_OPS-1:0]      op,
  output ctl_t                  ctl
);
  // product terms, one per tick/instruction pair that does work
  logic mv_ab_t2, mv_ba_t2, inc_a_t2, inc_a_t3, inc_b_t2, inc_b_t3;

  assign mv_ab_t2 = op[OP_MOV_A2B] & t[2];
  assign mv_ba_t2 = op[OP_MOV_B2A] & t[2];
  assign inc_a_t2 = op[OP_INC_A]   & t[2];
  assign inc_a_t3 = op[OP_INC_A]   & t[3];
  assign inc_b_t2 = op[OP_INC_B]   & t[2];
  assign inc_b_t3 = op[OP_INC_B]   & t[3];

  always_comb begin
    ctl           = '0;
    ctl.pc_drive  = t[0];
    ctl.mar_load  = t[0];
    ctl.pc_load   = t[1];
    ctl.sum_load  = t[0] | inc_a_t2 | inc_b_t2;
    ctl.sum_drive = t[1] | inc_a_t3 | inc_b_t3;
    ctl.a_load    = inc_a_t3 | mv_ba_t2;
    ctl.a_drive   = inc_a_t2 | mv_ab_t2;
    ctl.b_load    = inc_b_t3 | mv_ab_t2;
    ctl.b_drive   = inc_b_t2 | mv_ba_t2;
  end
endmodule

// File: rtl/tick_ctl_unit.sv
`timescale 1ns/1ps
module tick_ctl_unit
  import tick_ctl_pkg::*;
#(
  parameter int N_TICKS = 10,
  parameter int INSTR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [INSTR_W-1:0] instr,
  output logic [N_TICKS-1:0] tick,
  output logic               pc_load,
  output logic               pc_drive,
  output logic               mar_load,
  output logic               a_load,
  output logic               a_drive,
  output logic               b_load,
  output logic               b_drive,
  output logic               sum_load,
  output logic               sum_drive
);
  // named internal events for the checker
  logic                  wrap_evt;
  logic                  idle_tick;
  logic                  noop;
  logic [N_OPS-1:0]      op_line;
  logic [WORK_TICKS-1:0] work_t;
  ctl_t                  ctl;

  tick_ring #(.N(N_TICKS)) u_ring (
    .clk (clk),
    .rst (rst),
    .step(en),
    .ring(tick),
    .wrap(wrap_evt)
  );

  op_decode #(.W(INSTR_W), .LINES(N_OPS)) u_dec (
    .code(instr),
    .line(op_line),
    .noop(noop)
  );

  assign work_t    = tick[WORK_TICKS-1:0];
  assign idle_tick = |tick[N_TICKS-1:WORK_TICKS];

  ctl_matrix u_mat (
    .t  (work_t),
    .op (op_line),
    .ctl(ctl)
  );

  assign pc_load   = ctl.pc_load;
  assign pc_drive  = ctl.pc_drive;
  assign mar_load  = ctl.mar_load;
  assign a_load    = ctl.a_load;
  assign a_drive   = ctl.a_drive;
  assign b_load    = ctl.b_load;
  assign b_drive   = ctl.b_drive;
  assign sum_load  = ctl.sum_load;
  assign sum_drive = ctl.sum_drive;
endmodule

// File: rtl/tick_ctl_unit_chk.sv
`timescale 1ns/1ps
module tick_ctl_unit_chk #(
  parameter int N_TICKS = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [N_TICKS-1:0] tick,
  input logic               wrap_evt,
  input logic               idle_tick,
  input logic               noop,
  input logic               pc_load,
  input logic               pc_drive,
  input logic               mar_load,
  input logic               a_load,
  input logic               a_drive,
  input logic               b_load,
  input logic               b_drive,
  input logic               sum_load,
  input logic               sum_drive
);
  logic [8:0] all_en;
  assign all_en = {pc_load, pc_drive, mar_load, a_load, a_drive,
                   b_load, b_drive, sum_load, sum_drive};

  // R1
  reset_home_chk: assert property (@(posedge clk)
    rst |=> (tick == {{(N_TICKS-1){1'b0}}, 1'b1}));

  // R2
  one_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(tick) == 1);

  // R2
  rotate_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (tick[N_TICKS-1:1] == $past(tick[N_TICKS-2:0])) && (tick[0] == $past(tick[N_TICKS-1])));

  // R2
  wrap_home_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> tick[0]);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(tick));

  // R4
  fetch_t0_chk: assert property (@(posedge clk) disable iff (rst)
    tick[0] |-> (all_en == 9'b011000010));

  // R4
  fetch_t1_chk: assert property (@(posedge clk) disable iff (rst)
    tick[1] |-> (all_en == 9'b100000001));

  // R5
  noop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (noop && (tick[2] || tick[3])) |-> (all_en == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    idle_tick |-> (all_en == '0));

  // R9
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pc_drive, a_drive, b_drive, sum_drive}));
endmodule

bind tick_ctl_unit tick_ctl_unit_chk #(.N_TICKS(N_TICKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .tick     (tick),
  .wrap_evt (wrap_evt),
  .idle_tick(idle_tick),
  .noop     (noop),
  .pc_load  (pc_load),
  .pc_drive (pc_drive),
  .mar_load (mar_load),
  .a_load   (a_load),
  .a_drive  (a_drive),
  .b_load   (b_load),
  .b_drive  (b_drive),
  .sum_load (sum_load),
  .sum_drive(sum_drive)
);

// File: tb/sim_tick_ctl_unit.sv
`timescale 1ns/1ps
module sim_tick_ctl_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] instr = 4'd0;
  logic [9:0] tick;
  logic pc_load, pc_drive, mar_load, a_load, a_drive, b_load, b_drive, sum_load, sum_drive;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  bit started = 0;

  // reference state
  int ref_t = 0;
  bit was_rst = 0;
  bit was_hold = 0;

  always #2.5 clk = ~clk;

  tick_ctl_unit u0 (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .tick(tick),
    .pc_load(pc_load), .pc_drive(pc_drive), .mar_load(mar_load),
    .a_load(a_load), .a_drive(a_drive), .b_load(b_load), .b_drive(b_drive),
    .sum_load(sum_load), .sum_drive(sum_drive)
  );

  // expected enables, order {pc_load,pc_drive,mar_load,a_load,a_drive,b_load,b_drive,sum_load,sum_drive}
  function automatic logic [8:0] want(input int t, input int op);
    logic [8:0] w = '0;
    if (t == 0) begin w[7] = 1; w[6] = 1; w[1] = 1; end
    else if (t == 1) begin w[8] = 1; w[0] = 1; end
    else if (t == 2) begin
      case (op)
        0: begin w[4] = 1; w[3] = 1; end
        1: begin w[2] = 1; w[5] = 1; end
        2: begin w[4] = 1; w[1] = 1; end
        3: begin w[2] = 1; w[1] = 1; end
        default: ;
      endcase
    end else if (t == 3) begin
      if (op == 2) begin w[0] = 1; w[5] = 1; end
      if (op == 3) begin w[0] = 1; w[3] = 1; end
    end
    return w;
  endfunction

  function automatic string en_tag(input int t, input int op);
    if (t <= 1) return "R4";
    if (t >= 4) return "R8";
    if (op >= 4) return "R5";
    if (op <= 1) return "R6";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b (tick index %0d, instr %0d)", tag, got, exp, ref_t, instr);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // reference model: advances on each edge from the inputs held there
  always @(posedge clk) begin
    cycles <= cycles + 1;
    started <= 1;
    was_rst <= rst;
    was_hold <= !rst && !en;
    if (rst)      ref_t <= 0;
    else if (en)  ref_t <= (ref_t + 1) % 10;
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic [8:0] got_en;
      logic [9:0] exp_tick;
      string ttag;
      exp_tick = 10'd1 << ref_t;
      ttag = was_rst ? "R1" : (was_hold ? "R3" : "R2");
      check(ttag, tick, exp_tick);
      got_en = {pc_load, pc_drive, mar_load, a_load, a_drive, b_load, b_drive, sum_load, sum_drive};
      check(en_tag(ref_t, int'(instr)), {1'b0, got_en}, {1'b0, want(ref_t, int'(instr))});
      // R9: count drivers in every tick
      check("R9", 10'(int'(pc_drive) + int'(a_drive) + int'(b_drive) + int'(sum_drive) > 1), 10'd0);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog got=hung expected=finished");
      finish_up();
    end
  end

  task automatic step(input bit r, input bit e, input logic [3:0] op);
    @(posedge clk);
    #1;
    rst = r; en = e; instr = op;
  endtask

  initial begin
    int prog[6] = '{3, 3, 3, 1, 3, 0};
    // R1: reset held for several edges
    repeat (3) step(1, 1, 4'd2);
    // every code for a full cycle and more (R4..R8)
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 12; k++) step(0, 1, 4'(op));
    end
    // R3: stalls interleaved with steps
    for (int k = 0; k < 40; k++) step(0, (k % 3) != 0, 4'd2);
    for (int k = 0; k < 20; k++) step(0, (k % 2) != 0, 4'd1);
    // R1: reset in the middle of a cycle
    for (int k = 0; k < 5; k++) step(0, 1, 4'd3);
    step(1, 1, 4'd3);
    for (int k = 0; k < 12; k++) step(0, 1, 4'd3);
    // short program, one instruction per machine cycle
    step(1, 0, 4'd0);
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 10; k++) step(0, 1, 4'(prog[i]));
    end
    // mixed stimulus, instruction changing within a cycle
    for (int k = 0; k < 600; k++) step(($urandom % 50) == 0, ($urandom % 4) != 0, 4'($urandom % 16));
    step(0, 0, 4'd0);
    @(negedge clk);
    #1;
    finish_up();
  end
endmodule